// File: doc/BRIEF.md
# Two-Sample Stream Combiner

This block is the rate-halving stage placed between linear correlator sections of a multi-tau correlator. It receives two 16-bit sample streams that share one valid strobe. It adds each pair of consecutive valid samples on each stream and emits one summed sample for every two accepted. Summing rather than averaging keeps small photon-count values exact, at the cost of a doubled magnitude. Scaling that growth back down is the job of logic further down the chain.

A small controller with two states tracks the pairing. In `S_EMPTY` no sample is held. In `S_HALF` the first sample of a pair is held. The transitions are:

- `take`: from `S_EMPTY` to `S_HALF` on a valid sample that is not marked last.
- `pair`: from `S_HALF` to `S_EMPTY` on a valid sample. This transition emits the sum.
- `abort`: from `S_HALF` to `S_EMPTY` on an end-of-data flag with no valid sample. The held sample is dropped.
- `stay`: the state is kept in every other case. This includes a last-marked first sample in `S_EMPTY`, which is also dropped.

Every output is registered, so the summed data, the output strobe and the forwarded end-of-data flag all appear one clock after the input cycle that caused them.

Top module: `pair_sum_stage`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_vld and out_last are 0 and out_a and out_b are 0.
- R2: When a second valid sample of a pair is accepted, the next cycle shows out_a equal to the held A sample plus the current A sample, and likewise for out_b with the B stream.
- R3: out_vld is high for exactly one cycle, the cycle after every second accepted sample of a data set. It is never high in two consecutive cycles.
- R4: out_last equals in_last delayed by one clock, whether or not in_vld is high.
- R5: in_last without in_vld while one sample is held ends the data set. The held sample is dropped and produces no out_vld.
- R6: in_last together with in_vld on the second sample of a pair emits that pair normally. In_last with in_vld on the first sample drops that sample and produces no out_vld.
- R7: After any in_last, pairing restarts from the next valid sample. A dropped sample never contributes to a later sum.
- R8: While out_vld is low, out_a and out_b hold their previous values.
- R9: Sums wrap modulo 2^16, for example 0xFFFF + 0x0002 gives 0x0001. No overflow flag exists.
- R10: Idle cycles between valid samples do not affect pairing. Pairs are formed by strobe count, not by cycle count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input samples valid this cycle |
| in_a | input | 16 | A-stream input sample |
| in_b | input | 16 | B-stream input sample |
| in_last | input | 1 | Last valid sample of the data set has been given |
| out_vld | output | 1 | Summed outputs valid this cycle |
| out_a | output | 16 | Sum of a pair of A samples |
| out_b | output | 16 | Sum of a pair of B samples |
| out_last | output | 1 | End-of-data flag, delayed one clock |

## Verification
The bound checker watches several properties on every cycle:

- the one-clock forwarding of the end-of-data flag;
- the absence of back-to-back output strobes;
- the fact that an output strobe always follows an accepted input;
- the stability of the output data while the strobe is low.

Several behaviours can only be shown by the directed scenarios, because each depends on a whole sample history:

- the arithmetic value of each sum, including wrap-around;
- dropping an unpaired sample under both forms of end-of-data;
- a clean restart of pairing in the next data set;
- pairing across idle gaps.

// File: rtl/pair_sum_pkg.sv
package pair_sum_pkg;

    typedef enum logic {
        S_EMPTY = 1'b0,
        S_HALF  = 1'b1
    } pair_state_t;

    localparam int NUM_LANES = 2;

endpackage

// File: rtl/pair_sum_ctrl.sv
module pair_sum_ctrl
    import pair_sum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic in_last,
    output logic take,
    output logic emit,
    output logic clear,
    output logic vld_q,
    output logic last_q
);

    pair_state_t cur_st;
    pair_state_t nxt_st;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_st <= S_EMPTY;
        end else begin
            cur_st <= nxt_st;
        end
    end

    // next state and per-cycle controls
    always_comb begin
        nxt_st = cur_st;
        take   = 1'b0;
        emit   = 1'b0;
        clear  = 1'b0;
        unique case (cur_st)
            S_EMPTY: begin
                if (in_vld && !in_last) begin
                    take   = 1'b1;
                    nxt_st = S_HALF;
                end
                clear = in_last;
            end
            S_HALF: begin
                if (in_vld) begin
                    emit   = 1'b1;
                    clear  = 1'b1;
                    nxt_st = S_EMPTY;
                end else if (in_last) begin
                    clear  = 1'b1;
                    nxt_st = S_EMPTY;
                end
            end
            default: nxt_st = S_EMPTY;
        endcase
    end

    // registered strobes, aligned with the summed data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            last_q <= 1'b0;
        end else begin
            vld_q  <= emit;
            last_q <= in_last;
        end
    end

endmodule

// File: rtl/pair_sum_lane.sv
module pair_sum_lane #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          emit,
    input  logic          clear,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] held;
    logic [DW-1:0] sum_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= '0;
            sum_q <= '0;
        end else begin
            if (emit) begin
                sum_q <= held + din;
            end
            if (clear) begin
                held <= '0;
            end else if (take) begin
                held <= din;
            end
        end
    end

    assign dout = sum_q;

endmodule

// File: rtl/pair_sum_stage.sv
module pair_sum_stage
    import pair_sum_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic          in_last,
    output logic          out_vld,
    output logic [DW-1:0] out_a,
    output logic [DW-1:0] out_b,
    output logic          out_last
);

    logic take;
    logic emit;
    logic clear;

    logic [NUM_LANES-1:0][DW-1:0] lane_in;
    logic [NUM_LANES-1:0][DW-1:0] lane_out;

    assign lane_in[0] = in_a;
    assign lane_in[1] = in_b;

    pair_sum_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_last (in_last),
        .take    (take),
        .emit    (emit),
        .clear   (clear),
        .vld_q   (out_vld),
        .last_q  (out_last)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        pair_sum_lane #(.DW(DW)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (take),
            .emit  (emit),
            .clear (clear),
            .din   (lane_in[g]),
            .dout  (lane_out[g])
        );
    end

    assign out_a = lane_out[0];
    assign out_b = lane_out[1];

endmodule

// File: rtl/pair_sum_checker.sv
module pair_sum_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_vld,
    input logic          in_last,
    input logic          out_vld,
    input logic [DW-1:0] out_a,
    input logic [DW-1:0] out_b,
    input logic          out_last
);

    // R4: end-of-data forwarded one clock later
    a_r4_last_set: assert property (@(posedge clk) disable iff (!rst_n)
        in_last |=> out_last);
    a_r4_last_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !in_last |=> !out_last);

    // R3: output strobe never in two consecutive cycles
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);

    // R3: an output strobe follows an accepted input sample
    a_r3_vld_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // R8: data held while the strobe is low
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> ($stable(out_a) && $stable(out_b)));

endmodule

bind pair_sum_stage pair_sum_checker #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_last  (in_last),
    .out_vld  (out_vld),
    .out_a    (out_a),
    .out_b    (out_b),
    .out_last (out_last)
);

// File: tb/pair_sum_stage_tb.sv
module pair_sum_stage_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [15:0] in_a = '0;
    logic [15:0] in_b = '0;
    logic        in_last = 1'b0;
    logic        out_vld;
    logic [15:0] out_a;
    logic [15:0] out_b;
    logic        out_last;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pair_sum_stage #(.DW(16)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_a     (in_a),
        .in_b     (in_b),
        .in_last  (in_last),
        .out_vld  (out_vld),
        .out_a    (out_a),
        .out_b    (out_b),
        .out_last (out_last)
    );

    // drive one cycle of input at a falling edge, return at the next falling edge
    task automatic drive(input logic v, input logic [15:0] a, input logic [15:0] b,
                         input logic l);
        in_vld  = v;
        in_a    = a;
        in_b    = b;
        in_last = l;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic ev, input logic [15:0] ea,
                              input logic [15:0] eb, input logic el);
        checks++;
        if (out_vld !== ev || out_a !== ea || out_b !== eb || out_last !== el) begin
            errors++;
            $display("FAIL %s: got vld=%0b a=%h b=%h last=%0b, expected vld=%0b a=%h b=%h last=%0b",
                     req, out_vld, out_a, out_b, out_last, ev, ea, eb, el);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_out("R1 during reset", 1'b0, 16'h0, 16'h0, 1'b0);
        rst_n = 1'b1;
        drive(1'b0, 16'h0, 16'h0, 1'b0);
        expect_out("R1 after reset", 1'b0, 16'h0, 16'h0, 1'b0);
    endtask

    task automatic t_basic();
        drive(1'b1, 16'd1, 16'd2, 1'b0);
        expect_out("R3 first of pair", 1'b0, 16'd0, 16'd0, 1'b0);
        drive(1'b1, 16'd2, 16'd3, 1'b0);
        expect_out("R2 pair sum 3/5", 1'b1, 16'd3, 16'd5, 1'b0);
        drive(1'b1, 16'd3, 16'd4, 1'b0);
        expect_out("R8 hold after pair", 1'b0, 16'd3, 16'd5, 1'b0);
        drive(1'b1, 16'd4, 16'd5, 1'b1);
        expect_out("R6 last on second, sum 7/9", 1'b1, 16'd7, 16'd9, 1'b1);
        drive(1'b0, 16'd0, 16'd0, 1'b0);
        expect_out("R4 last cleared", 1'b0, 16'd7, 16'd9, 1'b0);
    endtask

    task automatic t_gaps();
        drive(1'b1, 16'd10, 16'd100, 1'b0);
        drive(1'b0, 16'd55, 16'd55, 1'b0);
        expect_out("R10 idle gap 1", 1'b0, 16'd7, 16'd9, 1'b0);
        drive(1'b0, 16'd66, 16'd66, 1'b0);
        expect_out("R10 idle gap 2", 1'b0, 16'd7, 16'd9, 1'b0);
        drive(1'b1, 16'd20, 16'd200, 1'b0);
        expect_out("R10 pair across gap", 1'b1, 16'd30, 16'd300, 1'b0);
        drive(1'b0, 16'd0, 16'd0, 1'b1);
        expect_out("R4 last alone forwarded", 1'b0, 16'd30, 16'd300, 1'b1);
        drive(1'b0, 16'd0, 16'd0, 1'b0);
    endtask

    task automatic t_odd_count();
        drive(1'b1, 16'd1, 16'd1, 1'b0);
        drive(1'b1, 16'd2, 16'd2, 1'b0);
        expect_out("R2 odd set pair", 1'b1, 16'd3, 16'd3, 1'b0);
        drive(1'b1, 16'd5, 16'd5, 1'b0);
        expect_out("R3 unpaired held", 1'b0, 16'd3, 16'd3, 1'b0);
        drive(1'b0, 16'd0, 16'd0, 1'b1);
        expect_out("R5 unpaired dropped", 1'b0, 16'd3, 16'd3, 1'b1);
        drive(1'b1, 16'd4, 16'd40, 1'b0);
        expect_out("R7 restart first", 1'b0, 16'd3, 16'd3, 1'b0);
        drive(1'b1, 16'd6, 16'd60, 1'b1);
        expect_out("R7 restart pair 10/100", 1'b1, 16'd10, 16'd100, 1'b1);
        drive(1'b0, 16'd0, 16'd0, 1'b0);
    endtask

    task automatic t_last_on_first();
        drive(1'b1, 16'd1, 16'd1, 1'b0);
        drive(1'b1, 16'd1, 16'd1, 1'b0);
        expect_out("R2 pair 2/2", 1'b1, 16'd2, 16'd2, 1'b0);
        drive(1'b1, 16'd8, 16'd8, 1'b1);
        expect_out("R6 last on first dropped", 1'b0, 16'd2, 16'd2, 1'b1);
        drive(1'b1, 16'd2, 16'd7, 1'b0);
        expect_out("R7 no leftover", 1'b0, 16'd2, 16'd2, 1'b0);
        drive(1'b1, 16'd3, 16'd9, 1'b0);
        expect_out("R7 fresh pair 5/16", 1'b1, 16'd5, 16'd16, 1'b0);
        drive(1'b0, 16'd0, 16'd0, 1'b1);
        drive(1'b0, 16'd0, 16'd0, 1'b0);
    endtask

    task automatic t_wrap();
        drive(1'b1, 16'hFFFF, 16'h8000, 1'b0);
        drive(1'b1, 16'h0002, 16'h8000, 1'b1);
        expect_out("R9 wrap", 1'b1, 16'h0001, 16'h0000, 1'b1);
        drive(1'b0, 16'd0, 16'd0, 1'b0);
        expect_out("R3 single strobe", 1'b0, 16'h0001, 16'h0000, 1'b0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_gaps();
        t_odd_count();
        t_last_on_first();
        t_wrap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule